// File: doc/BRIEF.md
# Packed-Lane Integer Vector ALU

This block performs one integer operation on every element of a 64-bit operand pair at the same time. At run time a size field selects how the 64 bits are split: eight 8-bit elements, four 16-bit elements or two 32-bit elements. A signedness flag selects whether each element is two's complement or unsigned. No carry or borrow passes from one element into the next. Each element saturates on its own.

The operations are add and subtract, each in a wrapping and a clamping form. There are also element-wise minimum and maximum, and equality and greater-than tests that produce masks. A horizontal sum folds every element of the first operand into one 64-bit scalar, which is the last step of a dot product. An operation is issued by raising the input valid with the operands, opcode, size and signedness flag. The result appears in a register one clock later, together with an output valid.

Top module: `simd_alu`

## Requirements
- R1: `lane_sz` 0 selects 8-bit elements, 1 selects 16-bit elements, and 2 or 3 select 32-bit elements. Element k occupies bits [k*w +: w]. No carry or borrow crosses an element boundary.
- R2: Opcode 0 (wrapping add) and opcode 2 (wrapping subtract, A minus B) give each element's result modulo 2^w.
- R3: When `is_signed`=1, opcode 1 (clamping add) and opcode 3 (clamping subtract) limit each element to the range from -2^(w-1) to 2^(w-1)-1.
- R4: When `is_signed`=0, opcodes 1 and 3 limit each element to the range from 0 to 2^w-1.
- R5: Opcode 4 returns the smaller element of A and B and opcode 5 returns the larger. The comparison is signed or unsigned according to `is_signed`.
- R6: Opcode 6 (A equal to B) and opcode 7 (A greater than B, signed or unsigned according to `is_signed`) write all ones into an element where the test holds and all zeros where it fails.
- R7: Opcode 8 returns the sum of all elements of A. Each element is sign-extended to 64 bits when `is_signed`=1 and zero-extended otherwise, and the sum wraps modulo 2^64. Operand B has no effect on this result.
- R8: `out_result` and `out_valid` change one clock after an edge at which `in_valid` is high. `out_valid` is high for exactly one cycle per accepted operation.
- R9: While `in_valid` is low, `out_result` holds its last value and `out_valid` is low.
- R10: While `rst_n` is low, `out_valid` and `out_result` are zero.
- R11: Opcodes 9 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issue strobe |
| opa | input | 64 | Packed operand A |
| opb | input | 64 | Packed operand B |
| opcode | input | 4 | Operation select |
| lane_sz | input | 2 | Element size select |
| is_signed | input | 1 | 1 = two's complement elements, 0 = unsigned |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 64 | Registered packed result |

## Verification
In a single issue, one element can clamp while the element next to it wraps or stays in range. Carry cutting and per-element saturation therefore act in the same cycle. The stimulus builds each element from a set of values at the range edges (zero, all ones, signed maximum, signed minimum) mixed with random values, so that overflowing and non-overflowing elements sit side by side. Every element of the registered result is compared against a bench model that computes each element independently.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    localparam int DATA_W = 64;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDS = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBS = 4'd3,
        OP_MIN  = 4'd4,
        OP_MAX  = 4'd5,
        OP_CEQ  = 4'd6,
        OP_CGT  = 4'd7,
        OP_RSUM = 4'd8
    } simd_op_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } simd_state_t;
endpackage

// File: rtl/simd_lane_ops.sv
module simd_lane_ops
    import simd_alu_pkg::*;
#(
    parameter int DW = 64,
    parameter int W  = 8
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [OP_W-1:0] op,
    input  logic            sgn,
    output logic [DW-1:0]   y
);
    localparam int LANES = DW / W;
    localparam int EW    = W + 2;
    localparam logic signed [EW-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [EW-1:0] SMIN = {3'b111, {(W-1){1'b0}}};
    localparam logic signed [EW-1:0] UMAX = {2'b00, {W{1'b1}}};
    localparam logic signed [EW-1:0] ZERO = '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [EW-1:0] ea, eb, sum, dif, hi, lo, sat_s, sat_d;
        logic                 gt;
        logic [W-1:0]         r;

        always_comb begin
            ea = $signed({{2{sgn & a[i*W+W-1]}}, a[i*W +: W]});
            eb = $signed({{2{sgn & b[i*W+W-1]}}, b[i*W +: W]});
            sum = ea + eb;
            dif = ea - eb;
            hi  = sgn ? SMAX : UMAX;
            lo  = sgn ? SMIN : ZERO;
            sat_s = (sum > hi) ? hi : ((sum < lo) ? lo : sum);
            sat_d = (dif > hi) ? hi : ((dif < lo) ? lo : dif);
            gt = ea > eb;
            case (simd_op_e'(op))
                OP_ADD:  r = sum[W-1:0];
                OP_ADDS: r = sat_s[W-1:0];
                OP_SUB:  r = dif[W-1:0];
                OP_SUBS: r = sat_d[W-1:0];
                OP_MIN:  r = gt ? eb[W-1:0] : ea[W-1:0];
                OP_MAX:  r = gt ? ea[W-1:0] : eb[W-1:0];
                OP_CEQ:  r = {W{ea == eb}};
                OP_CGT:  r = {W{gt}};
                default: r = '0;
            endcase
        end

        assign y[i*W +: W] = r;
    end
endmodule

// File: rtl/simd_reduce.sv
module simd_reduce #(
    parameter int DW     = 64,
    parameter int NSIZES = 3
) (
    input  logic [DW-1:0] a,
    input  logic [1:0]    sz,
    input  logic          sgn,
    output logic [DW-1:0] total
);
    logic [DW-1:0] sums [NSIZES];

    for (genvar k = 0; k < NSIZES; k++) begin : g_size
        localparam int W     = 8 << k;
        localparam int LANES = DW / W;
        logic [DW-1:0] acc;

        always_comb begin
            acc = '0;
            for (int j = 0; j < LANES; j++) begin
                acc = acc + {{(DW-W){sgn & a[j*W+W-1]}}, a[j*W +: W]};
            end
        end

        assign sums[k] = acc;
    end

    always_comb begin
        case (sz)
            2'd0:    total = sums[0];
            2'd1:    total = sums[1];
            default: total = sums[NSIZES-1];
        endcase
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [OP_W-1:0]   opcode,
    input  logic [1:0]        lane_sz,
    input  logic              is_signed,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int NSIZES = 3;

    logic [DATA_W-1:0] lane_y [NSIZES];
    logic [DATA_W-1:0] red_y;
    logic [DATA_W-1:0] vec_y;
    simd_state_t       st_d, st_q;

    for (genvar k = 0; k < NSIZES; k++) begin : g_unit
        logic [DATA_W-1:0] y_k;
        simd_lane_ops #(.DW(DATA_W), .W(8 << k)) u_ops (
            .a   (opa),
            .b   (opb),
            .op  (opcode),
            .sgn (is_signed),
            .y   (y_k)
        );
        assign lane_y[k] = y_k;
    end

    simd_reduce #(.DW(DATA_W), .NSIZES(NSIZES)) u_red (
        .a     (opa),
        .sz    (lane_sz),
        .sgn   (is_signed),
        .total (red_y)
    );

    always_comb begin
        case (lane_sz)
            2'd0:    vec_y = lane_y[0];
            2'd1:    vec_y = lane_y[1];
            default: vec_y = lane_y[NSIZES-1];
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = (simd_op_e'(opcode) == OP_RSUM) ? red_y : vec_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [OP_W-1:0]   opcode,
    input logic [1:0]        lane_sz,
    input logic              is_signed,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    // R8
    issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R6
    mask_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == OP_CEQ || opcode == OP_CGT)) |=>
        ((out_result[7:0] == 8'h00 || out_result[7:0] == 8'hFF) &&
         (out_result[63:56] == 8'h00 || out_result[63:56] == 8'hFF)));

    // R4
    usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_ADDS && lane_sz == 2'd2 && !is_signed) |=>
        (out_result[31:0] >= $past(opa[31:0])));

    // R7
    ured_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_RSUM && lane_sz == 2'd0 && !is_signed) |=>
        (out_result[63:11] == '0));

    // R11
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode > OP_RSUM) |=> (out_result == '0));
endmodule

bind simd_alu simd_alu_chk u_chk (.*);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] opa, opb;
    logic [3:0]  opcode;
    logic [1:0]  lane_sz;
    logic        is_signed;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_alu u0 (.*);

    function automatic int width_of(logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic longint lane_val(logic [63:0] v, int i, int w, logic s);
        longint x;
        x = longint'((v >> (i*w)) & ((64'd1 << w) - 64'd1));
        if (s && x[w-1]) x = x - (longint'(1) << w);
        return x;
    endfunction

    function automatic logic [63:0] ref_op(logic [63:0] a, logic [63:0] b,
                                           logic [3:0] op, logic [1:0] sz, logic s);
        int w;
        longint x, y, r, hi, lo;
        logic [63:0] out;
        w  = width_of(sz);
        hi = s ? (longint'(1) << (w-1)) - 1 : (longint'(1) << w) - 1;
        lo = s ? -(longint'(1) << (w-1)) : 0;
        out = '0;
        if (op == 4'd8) begin
            for (int i = 0; i < 64/w; i++) out = out + 64'(lane_val(a, i, w, s));
            return out;
        end
        if (op > 4'd8) return '0;
        for (int i = 0; i < 64/w; i++) begin
            x = lane_val(a, i, w, s);
            y = lane_val(b, i, w, s);
            case (op)
                4'd0, 4'd1: r = x + y;
                4'd2, 4'd3: r = x - y;
                4'd4:       r = (x < y) ? x : y;
                4'd5:       r = (x > y) ? x : y;
                4'd6:       r = (x == y) ? -1 : 0;
                default:    r = (x > y) ? -1 : 0;
            endcase
            if (op == 4'd1 || op == 4'd3) begin
                if (r > hi) r = hi;
                if (r < lo) r = lo;
            end
            out = out | ((64'(r) & ((64'd1 << w) - 64'd1)) << (i*w));
        end
        return out;
    endfunction

    function automatic string req_of(logic [3:0] op, logic s);
        case (op)
            4'd0, 4'd2: return "R2";
            4'd1, 4'd3: return s ? "R3" : "R4";
            4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8:       return "R7";
            default:    return "R11";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation, check result one cycle later (R8), then one idle cycle (R9).
    task automatic issue(logic [63:0] a, logic [63:0] b, logic [3:0] op,
                         logic [1:0] sz, logic s, string req);
        logic [63:0] exp, held;
        exp = ref_op(a, b, op, sz, s);
        @(negedge clk);
        opa = a; opb = b; opcode = op; lane_sz = sz; is_signed = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", {63'd0, out_valid}, 64'd1);
        check(req, out_result, exp);
        held = out_result;
        opa = ~a; opb = ~b; opcode = 4'd0;
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0);
        check("R9", out_result, held);
    endtask

    function automatic logic [63:0] pick_vec(logic [1:0] sz);
        int w;
        logic [63:0] v;
        logic [31:0] e;
        w = width_of(sz);
        v = '0;
        for (int i = 0; i < 64/w; i++) begin
            case ($urandom % 5)
                0: e = '0;
                1: e = '1;
                2: e = 32'h7FFF_FFFF >> (32 - w);
                3: e = 32'h1 << (w - 1);
                default: e = $urandom;
            endcase
            v = v | ((64'(e) & ((64'd1 << w) - 64'd1)) << (i*w));
        end
        return v;
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b1; opa = '1; opb = '1;
        opcode = 4'd0; lane_sz = 2'd0; is_signed = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", {63'd0, out_valid}, 64'd0);
        check("R10", out_result, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: carries cut at each element boundary in each size
        issue(64'h00FF_00FF_00FF_00FF, 64'h0101_0101_0101_0101, 4'd0, 2'd0, 1'b0, "R1");
        check("R1", out_result, 64'h0100_0100_0100_0100);
        issue(64'h0000_FFFF_0000_FFFF, 64'h0001_0001_0001_0001, 4'd0, 2'd1, 1'b0, "R1");
        issue(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 4'd0, 2'd2, 1'b0, "R1");
        check("R1", out_result, 64'd0);
        issue(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 4'd2, 2'd3, 1'b0, "R1");
        // R3: signed clamp both ways
        issue(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 4'd1, 2'd0, 1'b1, "R3");
        check("R3", out_result, 64'h7F7F_7F7F_7F7F_7F7F);
        issue(64'h8000_8000_8000_8000, 64'h0001_0001_0001_0001, 4'd3, 2'd1, 1'b1, "R3");
        // R4: unsigned clamp both ways
        issue(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 4'd3, 2'd2, 1'b0, "R4");
        check("R4", out_result, 64'd0);
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0304_0506_0708, 4'd1, 2'd0, 1'b0, "R4");
        // R5, R6: signed vs unsigned ordering
        issue(64'h80FF_0102_7F00_8001, 64'h7F01_0201_807F_0180, 4'd4, 2'd0, 1'b1, "R5");
        issue(64'h80FF_0102_7F00_8001, 64'h7F01_0201_807F_0180, 4'd5, 2'd0, 1'b0, "R5");
        issue(64'h8000_0000_1234_5678, 64'h7FFF_FFFF_1234_5678, 4'd7, 2'd2, 1'b1, "R6");
        issue(64'h8000_0000_1234_5678, 64'h7FFF_FFFF_1234_5678, 4'd6, 2'd2, 1'b0, "R6");
        // R7: horizontal sum, B ignored
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 4'd8, 2'd0, 1'b1, "R7");
        check("R7", out_result, 64'hFFFF_FFFF_FFFF_FFF8);
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd8, 2'd0, 1'b0, "R7");
        check("R7", out_result, 64'h0000_0000_0000_07F8);
        issue(64'h8000_0000_8000_0000, 64'hFFFF, 4'd8, 2'd2, 1'b1, "R7");
        // R11
        issue(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 4'd12, 2'd1, 1'b1, "R11");

        for (int n = 0; n < 400; n++) begin
            logic [1:0] sz;
            logic [3:0] op;
            logic       s;
            sz = 2'($urandom % 4);
            op = 4'($urandom % 10);
            if (op == 4'd9) op = 4'($urandom % 7 + 9);
            s  = 1'($urandom);
            issue(pick_vec(sz), pick_vec(sz), op, sz, s, req_of(op, s));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule